// File: doc/BRIEF.md
# Serial-to-Register Bridge with Burst Length Checking

This block is an SPI slave that turns framed serial transactions into accesses on an internal 32-bit register bus. A frame opens when chip select goes low. The first 32 bits form a header that names the operation, a 16-bit byte address and a declared word count. Whole 32-bit data words follow: the master sends them on a write, and the bridge returns them on a read. Each word in a burst targets the next word address.

When chip select goes high, the bridge compares the number of words actually moved with the declared count. Any difference sets sticky error flags. The words already transferred are kept. The flags sit in a small status word that the bridge serves itself at one fixed address. The master reads that word and clears bits by writing ones to them.

The serial pins are oversampled in the system clock domain. Each SCLK high phase and each low phase must last at least six system clocks. The register bus must answer a read within two clocks of the request.

Top module: `spi_regbridge`

## Requirements
- R1: SPI mode 0 applies: SCLK idles low, MOSI is sampled on the rising edge, and MISO changes after the falling edge, most significant bit first. Header bits 31:24 are the opcode. Bits 23:8 are the byte address, sent high byte first. Bits 7:0 are the declared word count.
- R2: On a write frame (opcode 0x02), each data word is issued as one bus write once all 32 of its bits have arrived. Its first byte is the word's most significant byte.
- R3: Inside a burst, each data word after the first uses the address of the previous word plus 4.
- R4: On a read frame (opcode 0x03), the bridge issues a bus read when the header completes and again after each data word. The data from each read is shifted out on MISO, MSB first, in the next word slot.
- R5: Flag bit 0 (write short) is set when chip select rises on a write frame with fewer complete words than declared. A partial word inside the count also sets it. The complete words are still written.
- R6: Flag bit 1 (write long) is set when a write frame carries more complete words than declared, or a partial word beyond the count. The extra complete words are still written.
- R7: Flag bit 2 (read short) is set when a read frame ends before the declared number of complete words.
- R8: Flag bit 3 (read long) is set when a read frame clocks out more than the declared words, counting a partial word beyond the count.
- R9: Flag bit 4 (frame error) is set when chip select rises after 1 to 31 header bits, or when the opcode is neither 0x02 nor 0x03. Such frames cause no bus write.
- R10: Flag bit 5 is a summary bit. It is set whenever any of bits 4:0 is set, and it stays set until cleared.
- R11: Address 0x000C is answered inside the bridge and never reaches the bus. A read returns the six flags in bits 5:0 with zeros above. A write clears each flag whose data bit is 1.
- R12: A data word cut short by chip select causes no bus access.
- R13: After reset, all flags are 0, bus_req is 0 and spi_miso is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_csn | input | 1 | Active-low chip select that bounds a frame |
| spi_mosi | input | 1 | Serial data into the bridge |
| spi_miso | output | 1 | Serial data out of the bridge |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_we | output | 1 | 1 for a write access, 0 for a read |
| bus_addr | output | 16 | Byte address of the access |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | One-cycle acknowledge from the register bus |
| bus_rdata | input | 32 | Read data, valid with bus_ack |
| err_flags | output | 6 | Sticky flags: 0 write short, 1 write long, 2 read short, 3 read long, 4 frame error, 5 summary |

## Verification
A wrong bit or word counter appears on the error flags within a few clocks of chip select rising. It also moves a burst write to the wrong address, which shows when the memory behind the bus is later compared. A bad prefetch or shift state corrupts the very next word on MISO, so a read burst exposes it inside the same frame. A flag that drops on its own, or a status access that leaks onto the bus, shows at the next status read or at the next frame's flag check.

// File: rtl/spi_regbridge_pkg.sv
// Shared constants and types for the serial register bridge.
// Assumes the header is exactly one bus word wide.
package spi_regbridge_pkg;
    localparam int ADDR_W   = 16;
    localparam int WORD_W   = 32;
    localparam int OP_W     = 8;
    localparam int CNT_W    = 8;
    localparam int BIT_W    = $clog2(WORD_W);
    localparam int FLAG_W   = 6;
    localparam int SET_W    = FLAG_W - 1;

    localparam int FL_WR_SHORT = 0;
    localparam int FL_WR_LONG  = 1;
    localparam int FL_RD_SHORT = 2;
    localparam int FL_RD_LONG  = 3;
    localparam int FL_FRAME    = 4;
    localparam int FL_SUM      = 5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_WR,
        PH_RD,
        PH_BAD
    } phase_t;
endpackage

// File: rtl/spi_regbridge_sync.sv
// Brings SCLK, chip select and MOSI into the system clock domain and
// produces single-cycle edge strobes.
// Assumes each SCLK phase lasts several system clocks.
module spi_regbridge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic csn,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_begin,
    output logic cs_end,
    output logic cs_act,
    output logic mosi_s
);
    logic [STAGES:0]   sclk_q;
    logic [STAGES:0]   csn_q;
    logic [STAGES-1:0] mosi_q;

    // Purpose: shift the raw pins through the synchroniser chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
            csn_q  <= '1;
            mosi_q <= '0;
        end else begin
            sclk_q <= {sclk_q[STAGES-1:0], sclk};
            csn_q  <= {csn_q[STAGES-1:0], csn};
            mosi_q <= {mosi_q[STAGES-2:0], mosi};
        end
    end

    // Purpose: compare the last two stages to find the edges.
    always_comb begin
        sclk_rise = sclk_q[STAGES-1] & ~sclk_q[STAGES];
        sclk_fall = ~sclk_q[STAGES-1] & sclk_q[STAGES];
        cs_begin  = ~csn_q[STAGES-1] & csn_q[STAGES];
        cs_end    = csn_q[STAGES-1] & ~csn_q[STAGES];
        cs_act    = ~csn_q[STAGES-1];
        mosi_s    = mosi_q[STAGES-1];
    end
endmodule

// File: rtl/spi_regbridge_frame.sv
// Frame engine. It counts bits into the header and the data words,
// decodes the header, issues one access for each complete unit, shifts
// read data out on MISO and judges the frame length when chip select
// rises.
// Assumes each access completes before the next unit does.
module spi_regbridge_frame
    import spi_regbridge_pkg::*;
#(
    parameter logic [OP_W-1:0] OP_WR = 8'h02,
    parameter logic [OP_W-1:0] OP_RD = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_begin,
    input  logic              cs_end,
    input  logic              cs_act,
    input  logic              mosi_s,
    input  logic [WORD_W-1:0] rd_word,
    output logic              acc_go,
    output logic              acc_we,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [WORD_W-1:0] acc_wdata,
    output logic [SET_W-1:0]  err_set,
    output logic              miso
);
    localparam int WCNT_W = CNT_W + 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

    phase_t             phase;
    logic [BIT_W-1:0]   bit_cnt;
    logic [WORD_W-1:0]  rx_sh;
    logic [WORD_W-1:0]  tx_sh;
    logic [WCNT_W-1:0]  words;
    logic [CNT_W-1:0]   decl;
    logic [ADDR_W-1:0]  next_addr;
    logic               load_pend;
    logic [WORD_W-1:0]  rx_full;
    logic               excess;
    logic               shortf;

    // Purpose: form the unit being shifted in and the length verdict.
    always_comb begin
        rx_full = {rx_sh[WORD_W-2:0], mosi_s};
        excess  = (words > {1'b0, decl}) ||
                  ((words == {1'b0, decl}) && (bit_cnt != '0));
        shortf  = !excess && (words < {1'b0, decl});
    end

    // Purpose: run the frame sequence, the accesses and the MISO shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            words     <= '0;
            decl      <= '0;
            next_addr <= '0;
            load_pend <= 1'b0;
            acc_go    <= 1'b0;
            acc_we    <= 1'b0;
            acc_addr  <= '0;
            acc_wdata <= '0;
            err_set   <= '0;
        end else begin
            acc_go  <= 1'b0;
            err_set <= '0;
            if (cs_begin) begin
                phase     <= PH_HDR;
                bit_cnt   <= '0;
                words     <= '0;
                tx_sh     <= '0;
                load_pend <= 1'b0;
            end else if (cs_end) begin
                phase     <= PH_IDLE;
                tx_sh     <= '0;
                load_pend <= 1'b0;
                unique case (phase)
                    PH_HDR: err_set[FL_FRAME] <= (bit_cnt != '0);
                    PH_BAD: err_set[FL_FRAME] <= 1'b1;
                    PH_WR: begin
                        err_set[FL_WR_LONG]  <= excess;
                        err_set[FL_WR_SHORT] <= shortf;
                    end
                    PH_RD: begin
                        err_set[FL_RD_LONG]  <= excess;
                        err_set[FL_RD_SHORT] <= shortf;
                    end
                    default: ;
                endcase
            end else if (sclk_rise && phase != PH_IDLE) begin
                rx_sh   <= rx_full;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) begin
                    unique case (phase)
                        PH_HDR: begin
                            decl      <= rx_full[CNT_W-1:0];
                            next_addr <= rx_full[CNT_W +: ADDR_W];
                            if (rx_full[WORD_W-1 -: OP_W] == OP_WR) begin
                                phase <= PH_WR;
                            end else if (rx_full[WORD_W-1 -: OP_W] == OP_RD) begin
                                phase     <= PH_RD;
                                acc_go    <= 1'b1;
                                acc_we    <= 1'b0;
                                acc_addr  <= rx_full[CNT_W +: ADDR_W];
                                next_addr <= rx_full[CNT_W +: ADDR_W] + STEP;
                                load_pend <= 1'b1;
                            end else begin
                                phase <= PH_BAD;
                            end
                        end
                        PH_WR: begin
                            acc_go    <= 1'b1;
                            acc_we    <= 1'b1;
                            acc_addr  <= next_addr;
                            acc_wdata <= rx_full;
                            next_addr <= next_addr + STEP;
                            if (words != '1) words <= words + 1'b1;
                        end
                        PH_RD: begin
                            acc_go    <= 1'b1;
                            acc_we    <= 1'b0;
                            acc_addr  <= next_addr;
                            next_addr <= next_addr + STEP;
                            load_pend <= 1'b1;
                            if (words != '1) words <= words + 1'b1;
                        end
                        default: ;
                    endcase
                end
            end else if (sclk_fall && cs_act) begin
                if (load_pend) begin
                    tx_sh     <= rd_word;
                    load_pend <= 1'b0;
                end else begin
                    tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
                end
            end
        end
    end

    assign miso = tx_sh[WORD_W-1];

    // R12: an access is launched only as the bit counter wraps after a full unit
    a_r12_whole_unit: assert property (@(posedge clk) disable iff (!rst_n)
        acc_go |-> (bit_cnt == '0));

    // R9: a frame with a bad opcode launches nothing
    a_r9_bad_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_BAD) |-> !acc_go);

    // R3: consecutive accesses in one frame are one word apart
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && phase != PH_IDLE) |=> (next_addr == acc_addr + STEP));
endmodule

// File: rtl/spi_regbridge_access.sv
// Access engine. It drives the register bus with a request that is held
// until acknowledged, serves the status word at one fixed address and
// keeps the sticky flags.
// Assumes at most one access is outstanding at a time.
module spi_regbridge_access
    import spi_regbridge_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'h000C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_go,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [WORD_W-1:0] acc_wdata,
    input  logic [SET_W-1:0]  err_set,
    input  logic              bus_ack,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] rd_word,
    output logic [FLAG_W-1:0] flags
);
    logic              is_stat;
    logic [FLAG_W-1:0] clr_mask;
    logic [FLAG_W-1:0] flags_nx;

    // Purpose: decode local status accesses and compute the next flags.
    always_comb begin
        is_stat  = acc_go && (acc_addr == STAT_ADDR);
        clr_mask = (is_stat && acc_we) ? acc_wdata[FLAG_W-1:0] : '0;
        flags_nx = (flags & ~clr_mask) | {|err_set, err_set};
    end

    // Purpose: run the bus handshake, capture read data, update the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
            rd_word   <= '0;
            flags     <= '0;
        end else begin
            flags <= flags_nx;
            if (is_stat) begin
                if (!acc_we) rd_word <= {{(WORD_W-FLAG_W){1'b0}}, flags};
            end else if (acc_go) begin
                bus_req   <= 1'b1;
                bus_we    <= acc_we;
                bus_addr  <= acc_addr;
                bus_wdata <= acc_wdata;
            end
            if (bus_req && bus_ack) begin
                bus_req <= 1'b0;
                if (!bus_we) rd_word <= bus_rdata;
            end
        end
    end

    // R2: a request holds steady until acknowledged
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                                   $stable(bus_we) && $stable(bus_wdata)));

    // R11: the status word never appears on the bus
    a_r11_local_status: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_addr != STAT_ADDR));

    // R10: any new error raises the summary bit
    a_r10_summary_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_set) |=> flags[FL_SUM]);

    // R5: a flag stays set unless a one is written to it
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FL_WR_SHORT] && !clr_mask[FL_WR_SHORT]) |=> flags[FL_WR_SHORT]);

    // R2: a new bus access never lands on an outstanding one
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go && !is_stat) |-> !bus_req);
endmodule

// File: rtl/spi_regbridge.sv
// Top of the serial register bridge: synchroniser, frame engine and
// access engine.
// Assumes each SCLK phase lasts at least six system clocks and that a
// bus read is answered within two clocks.
module spi_regbridge
    import spi_regbridge_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [OP_W-1:0]   OP_WRITE    = 8'h02,
    parameter logic [OP_W-1:0]   OP_READ     = 8'h03,
    parameter logic [ADDR_W-1:0] STAT_ADDR   = 16'h000C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic [FLAG_W-1:0] err_flags
);
    logic              sclk_rise, sclk_fall, cs_begin, cs_end, cs_act, mosi_s;
    logic              acc_go, acc_we;
    logic [ADDR_W-1:0] acc_addr;
    logic [WORD_W-1:0] acc_wdata;
    logic [WORD_W-1:0] rd_word;
    logic [SET_W-1:0]  err_set;

    spi_regbridge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (spi_sclk),
        .csn       (spi_csn),
        .mosi      (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_begin  (cs_begin),
        .cs_end    (cs_end),
        .cs_act    (cs_act),
        .mosi_s    (mosi_s)
    );

    spi_regbridge_frame #(.OP_WR(OP_WRITE), .OP_RD(OP_READ)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_begin  (cs_begin),
        .cs_end    (cs_end),
        .cs_act    (cs_act),
        .mosi_s    (mosi_s),
        .rd_word   (rd_word),
        .acc_go    (acc_go),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .err_set   (err_set),
        .miso      (spi_miso)
    );

    spi_regbridge_access #(.STAT_ADDR(STAT_ADDR)) u_access (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_go    (acc_go),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .err_set   (err_set),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .rd_word   (rd_word),
        .flags     (err_flags)
    );

    // R13: reset leaves the bus idle and the flags clear
    a_r13_reset_idle: assert property (@(posedge clk)
        $past(!rst_n) |-> (!bus_req && err_flags == '0 && !spi_miso));
endmodule

// File: tb/spi_regbridge_bench.sv
// Self-checking bench: directed corner frames followed by seeded random
// frames, checked against a bench-side memory and flag model.
module spi_regbridge_bench;
    localparam int CLK_P   = 10;
    localparam int HALF    = 6;
    localparam int WDOG    = 190000;
    localparam logic [7:0]  OPW  = 8'h02;
    localparam logic [7:0]  OPR  = 8'h03;
    localparam logic [15:0] STAT = 16'h000C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sclk = 1'b0;
    logic        spi_csn = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        bus_req, bus_we, bus_ack;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [5:0]  err_flags;

    logic [31:0] dev_mem [0:63];
    logic [31:0] exp_mem [0:63];
    logic [31:0] wbuf [0:7];
    logic [31:0] rbuf [0:7];
    int          wr_cnt = 0;
    int          exp_wr = 0;
    logic [5:0]  exp_flags = '0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    spi_regbridge u_spi_regbridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (spi_sclk),
        .spi_csn   (spi_csn),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .err_flags (err_flags)
    );

    always #(CLK_P/2) clk = ~clk;

    initial begin
        for (int i = 0; i < 64; i++) begin
            dev_mem[i] = 32'hC0DE_0000 ^ (i * 32'h0101_0101);
            exp_mem[i] = 32'hC0DE_0000 ^ (i * 32'h0101_0101);
        end
    end

    // Register bus model: acknowledge each request one clock later.
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else if (bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            if (bus_we) begin
                dev_mem[bus_addr[7:2]] <= bus_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                bus_rdata <= dev_mem[bus_addr[7:2]];
            end
        end else begin
            bus_ack <= 1'b0;
        end
    end

    function automatic int idx(input logic [15:0] a);
        return int'(a[7:2]);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic xfer(input logic [31:0] d, input int nb, output logic [31:0] q);
        q = '0;
        for (int i = 0; i < nb; i++) begin
            spi_mosi = d[31-i];
            repeat (HALF) @(negedge clk);
            q = {q[30:0], spi_miso};
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    // Run one frame, update the model and check flags, reads and writes.
    task automatic run_frame(input logic [7:0] op, input logic [15:0] addr,
                             input logic [7:0] cnt, input int nw, input int pb,
                             input int hb);
        logic [31:0] junk;
        logic        excess, shortf;
        string       ftag;
        @(negedge clk);
        spi_csn = 1'b0;
        repeat (HALF) @(negedge clk);
        xfer({op, addr, cnt}, hb, junk);
        if (hb == 32) begin
            for (int w = 0; w < nw; w++) xfer(wbuf[w], 32, rbuf[w]);
            if (pb > 0) xfer(wbuf[nw], pb, junk);
        end
        repeat (HALF) @(negedge clk);
        spi_csn = 1'b1;
        repeat (4*HALF) @(negedge clk);

        excess = (nw > int'(cnt)) || (nw == int'(cnt) && pb > 0);
        shortf = !excess && (nw < int'(cnt));
        ftag = "R2";
        if (hb != 32 || (op != OPW && op != OPR)) begin
            if (hb != 0) exp_flags[4] = 1'b1;
            ftag = "R9";
        end else if (op == OPW) begin
            for (int w = 0; w < nw; w++) begin
                if (addr + 16'(4*w) == STAT) begin
                    exp_flags = exp_flags & ~wbuf[w][5:0];
                    ftag = "R11";
                end else begin
                    exp_mem[idx(addr + 16'(4*w))] = wbuf[w];
                    exp_wr++;
                end
            end
            if (excess) begin exp_flags[1] = 1'b1; ftag = "R6"; end
            if (shortf) begin exp_flags[0] = 1'b1; ftag = "R5"; end
        end else begin
            ftag = "R4";
            for (int w = 0; w < nw; w++) begin
                if (addr + 16'(4*w) == STAT)
                    chk("R11", "status read", rbuf[w], {26'b0, exp_flags});
                else
                    chk("R4", "read word", rbuf[w], exp_mem[idx(addr + 16'(4*w))]);
            end
            if (excess) begin exp_flags[3] = 1'b1; ftag = "R8"; end
            if (shortf) begin exp_flags[2] = 1'b1; ftag = "R7"; end
        end
        if (|exp_flags[4:0] && (excess || shortf || ftag == "R9"))
            exp_flags[5] = 1'b1;
        chk(ftag, "flags", 32'(err_flags), 32'(exp_flags));
        chk(pb > 0 ? "R12" : ftag, "bus writes", 32'(wr_cnt), 32'(exp_wr));
    endtask

    task automatic clear_status();
        wbuf[0] = 32'h0000_003F;
        run_frame(OPW, STAT, 8'd1, 1, 0, 32);
        chk("R11", "flags after clear", 32'(err_flags), 32'h0);
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13", "reset flags", 32'(err_flags), 32'h0);
        chk("R13", "reset bus_req", 32'(bus_req), 32'h0);
        chk("R13", "reset miso", 32'(spi_miso), 32'h0);

        // Exact write burst, then exact read back.
        wbuf[0] = 32'h1234_5678; wbuf[1] = 32'h9ABC_DEF0; wbuf[2] = 32'h0F1E_2D3C;
        run_frame(OPW, 16'h0150, 8'd3, 3, 0, 32);
        chk("R1", "header/byte order", dev_mem[idx(16'h0150)], 32'h1234_5678);
        chk("R3", "burst step", dev_mem[idx(16'h0158)], 32'h0F1E_2D3C);
        run_frame(OPR, 16'h0150, 8'd3, 3, 0, 32);

        // Short write with a partial word inside the count.
        wbuf[0] = 32'hAAAA_5555; wbuf[1] = 32'hDEAD_BEEF;
        run_frame(OPW, 16'h0180, 8'd3, 1, 13, 32);
        chk("R10", "summary", 32'(err_flags[5]), 32'h1);
        run_frame(OPR, STAT, 8'd1, 1, 0, 32);
        clear_status();

        // Long write: extra words still committed.
        wbuf[0] = 32'h1111_1111; wbuf[1] = 32'h2222_2222; wbuf[2] = 32'h3333_3333;
        run_frame(OPW, 16'h01A0, 8'd1, 2, 7, 32);
        clear_status();

        // Read short and read long.
        run_frame(OPR, 16'h0150, 8'd3, 1, 0, 32);
        run_frame(OPR, 16'h0150, 8'd1, 2, 0, 32);
        run_frame(OPR, STAT, 8'd1, 1, 0, 32);
        clear_status();

        // Bad opcode with data, then a truncated header.
        wbuf[0] = 32'hFFFF_FFFF;
        run_frame(8'h7E, 16'h0100, 8'd1, 1, 0, 32);
        run_frame(OPW, 16'h0100, 8'd1, 0, 0, 17);
        clear_status();

        // Seeded random frames.
        for (int f = 0; f < 28; f++) begin
            int kind, nw, pb, hb;
            logic [7:0]  cnt;
            logic [15:0] a;
            kind = int'($urandom % 10);
            a    = 16'h0100 + 16'(($urandom % 32) * 4);
            cnt  = 8'($urandom % 4);
            nw   = int'(cnt);
            if ($urandom % 3 == 0) nw = nw + 1;
            else if ($urandom % 3 == 0 && nw > 0) nw = nw - 1;
            pb   = ($urandom % 5 == 0) ? int'(1 + $urandom % 31) : 0;
            hb   = 32;
            for (int w = 0; w < 8; w++) wbuf[w] = $urandom;
            if (kind < 4)      run_frame(OPW, a, cnt, nw, pb, hb);
            else if (kind < 8) run_frame(OPR, a, cnt, nw, pb, hb);
            else if (kind < 9) run_frame(8'h55, a, cnt, nw, pb, hb);
            else               run_frame(OPR, a, cnt, 0, 0, int'(1 + $urandom % 31));
            if (f % 6 == 5) begin
                run_frame(OPR, STAT, 8'd1, 1, 0, 32);
                clear_status();
            end
        end

        for (int i = 0; i < 64; i++)
            chk("R3", "memory image", dev_mem[i], exp_mem[i]);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule